// File: doc/BRIEF.md
# Processor Major State Sequencer

This block holds the major cycle of a small word-oriented processor control unit and picks the cycle that follows at each end-of-cycle strobe. While the machine runs, it moves through instruction fetch, an optional indirect-address cycle (defer) and operand execution. The choice after fetch comes from two decoded bits of the instruction just read: whether it references memory, and its indirect flag.

Three more states serve the operator panel: load address, deposit and examine. While the machine is halted, a one-shot pulse from one of these buttons selects the matching state. The run control then starts the machine for a single cycle. At that cycle's strobe the block raises a halt request and goes back to fetch. All six states are presented as one-hot outputs for the datapath.

Top module: `major_state_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block enters fetch (only `st_fetch` high) and `halt_req` is low.
- R2: Exactly one of the six state outputs is high in every cycle.
- R3: Apart from panel entry, the state changes only at a clock edge where `cyc_end` and `run` are both high. A strobe seen with `run` low is ignored.
- R4: At a strobe in fetch with `mem_ref` low, the next state is fetch, whatever `ind_bit` is.
- R5: At a strobe in fetch with `mem_ref` high and `ind_bit` low, the next state is execute.
- R6: At a strobe in fetch with `mem_ref` and `ind_bit` both high, the next state is defer. At a strobe in defer, the next state is execute.
- R7: At a strobe in execute, the next state is fetch.
- R8: With `run` low, a pulse on any panel button loads its panel state at that clock edge. If several are pressed together, load address wins over deposit, and deposit wins over examine.
- R9: Panel button pulses while `run` is high have no effect on the state.
- R10: In a panel state, `halt_req` is high during the cycle in which `cyc_end` and `run` are both high, and the next state is fetch. `halt_req` is low at all other times.
- R11: `mem_ref` and `ind_bit` have no effect outside fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_end | input | 1 | End-of-cycle strobe, one clock wide |
| run | input | 1 | Machine running |
| mem_ref | input | 1 | Fetched instruction references memory |
| ind_bit | input | 1 | Indirect flag of fetched instruction |
| btn_load | input | 1 | Load-address button pulse |
| btn_dep | input | 1 | Deposit button pulse |
| btn_exam | input | 1 | Examine button pulse |
| st_fetch | output | 1 | Fetch cycle |
| st_defer | output | 1 | Indirect-address cycle |
| st_exec | output | 1 | Execute cycle |
| st_load | output | 1 | Load-address panel cycle |
| st_dep | output | 1 | Deposit panel cycle |
| st_exam | output | 1 | Examine panel cycle |
| halt_req | output | 1 | Stop after this panel cycle |

## Verification
The bench sends strobes while the machine is halted. A design that ignores `run` would step through the cycles without the machine running. It also presses buttons while the machine runs, both with and without a strobe in the same cycle. A design that does not gate the buttons would jump into a panel state in the middle of an instruction. Simultaneous presses check the priority order, and a second press while halted must replace a pending panel state. An indirect bit on a non-memory instruction, and memory flags held high in the other states, show up as a stray defer or execute cycle in a design that decodes those flags too broadly.

// File: rtl/msq_pkg.sv
// Shared constants and types for the major state sequencer.
// Assumes one-hot state encoding: CPU states in the low bits, panel states above.
package msq_pkg;
    localparam int N_CPU   = 3;
    localparam int N_PANEL = 3;
    localparam int N_ST    = N_CPU + N_PANEL;

    localparam int S_FETCH = 0;
    localparam int S_DEFER = 1;
    localparam int S_EXEC  = 2;
    localparam int S_LOAD  = 3;
    localparam int S_DEP   = 4;
    localparam int S_EXAM  = 5;

    typedef logic [N_ST-1:0]    st_vec_t;
    typedef logic [N_PANEL-1:0] panel_vec_t;

    localparam st_vec_t FETCH_VEC = st_vec_t'(1) << S_FETCH;
    localparam st_vec_t DEFER_VEC = st_vec_t'(1) << S_DEFER;
    localparam st_vec_t EXEC_VEC  = st_vec_t'(1) << S_EXEC;
endpackage

// File: rtl/msq_panel_arb.sv
// Fixed-priority arbiter for panel button pulses.
// Assumes bit 0 has the highest priority. The grant is one-hot or zero.
module msq_panel_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pri
            if (i == 0) begin : g_top
                // Highest priority passes unmasked
                assign grant[i] = req[i];
            end else begin : g_low
                // Lower requests masked by any higher one
                assign grant[i] = req[i] & ~(|req[i-1:0]);
            end
        end
    endgenerate

    // Any button pressed
    assign any = |req;
endmodule

// File: rtl/msq_cycle_next.sv
// Next-state choice for a running machine at an end-of-cycle strobe.
// Assumes a one-hot current state; panel states and execute return to fetch.
module msq_cycle_next
    import msq_pkg::*;
(
    input  st_vec_t cur,
    input  logic    mem_ref,
    input  logic    ind_bit,
    output st_vec_t nxt,
    output logic    in_panel
);
    // Follow fetch -> (defer) -> execute -> fetch
    always_comb begin
        nxt = FETCH_VEC;
        if (cur[S_FETCH]) begin
            if (mem_ref && ind_bit)
                nxt = DEFER_VEC;
            else if (mem_ref)
                nxt = EXEC_VEC;
            else
                nxt = FETCH_VEC;
        end else if (cur[S_DEFER]) begin
            nxt = EXEC_VEC;
        end
    end

    // Panel states occupy the upper bits
    assign in_panel = |cur[N_ST-1:N_CPU];
endmodule

// File: rtl/msq_state_reg.sv
// One-hot major state register with synchronous active-low reset to fetch.
// Assumes the load value is one-hot whenever load_en is high.
module msq_state_reg
    import msq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load_en,
    input  st_vec_t d,
    output st_vec_t q
);
    // Hold or take the chosen next state
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= FETCH_VEC;
        else if (load_en)
            q <= d;
    end

    // R2
    onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q) == 1);

    // R1
    reset_fetch_chk: assert property (@(posedge clk)
        !rst_n |=> (q == FETCH_VEC));
endmodule

// File: rtl/major_state_seq.sv
// Major state sequencer: tracks fetch/defer/execute while running and the
// three single-cycle panel states entered from the halted machine.
// Assumes cyc_end is a one-clock strobe and panel buttons are one-clock pulses.
module major_state_seq
    import msq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_end,
    input  logic run,
    input  logic mem_ref,
    input  logic ind_bit,
    input  logic btn_load,
    input  logic btn_dep,
    input  logic btn_exam,
    output logic st_fetch,
    output logic st_defer,
    output logic st_exec,
    output logic st_load,
    output logic st_dep,
    output logic st_exam,
    output logic halt_req
);
    st_vec_t    state_q;
    st_vec_t    run_nxt;
    st_vec_t    d_sel;
    panel_vec_t btn_req;
    panel_vec_t btn_grant;
    logic       btn_any;
    logic       in_panel;
    logic       strobe_live;
    logic       panel_take;

    // Bit 0 is load address, the highest priority
    assign btn_req = {btn_exam, btn_dep, btn_load};

    msq_panel_arb #(.N(N_PANEL)) u_arb (
        .req   (btn_req),
        .grant (btn_grant),
        .any   (btn_any)
    );

    msq_cycle_next u_next (
        .cur      (state_q),
        .mem_ref  (mem_ref),
        .ind_bit  (ind_bit),
        .nxt      (run_nxt),
        .in_panel (in_panel)
    );

    // Strobe counts only while running; buttons only while halted
    assign strobe_live = cyc_end & run;
    assign panel_take  = ~run & btn_any;

    // Pick panel entry or sequenced next state
    always_comb begin
        if (panel_take)
            d_sel = {btn_grant, {N_CPU{1'b0}}};
        else
            d_sel = run_nxt;
    end

    msq_state_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (panel_take | strobe_live),
        .d       (d_sel),
        .q       (state_q)
    );

    // Drive state outputs and the halt request
    assign st_fetch = state_q[S_FETCH];
    assign st_defer = state_q[S_DEFER];
    assign st_exec  = state_q[S_EXEC];
    assign st_load  = state_q[S_LOAD];
    assign st_dep   = state_q[S_DEP];
    assign st_exam  = state_q[S_EXAM];
    assign halt_req = strobe_live & in_panel;

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cyc_end && run) && !(!run && (btn_load || btn_dep || btn_exam)))
        |=> $stable(state_q));

    // R9
    run_btn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cyc_end) |=> $stable(state_q));

    // R6
    defer_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_defer) |-> $past(st_fetch && run && cyc_end && mem_ref && ind_bit));

    // R6
    defer_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_defer && run && cyc_end) |=> st_exec);

    // R7
    exec_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_exec && run && cyc_end) |=> st_fetch);

    // R10
    halt_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> st_fetch);

    // R10
    halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (run && cyc_end && (st_load || st_dep || st_exam)));
endmodule

// File: tb/major_state_seq_bench.sv
`timescale 1ns/1ps
module major_state_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_end = 1'b0, run = 1'b0, mem_ref = 1'b0, ind_bit = 1'b0;
    logic btn_load = 1'b0, btn_dep = 1'b0, btn_exam = 1'b0;
    logic st_fetch, st_defer, st_exec, st_load, st_dep, st_exam, halt_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    major_state_seq u_major_state_seq (
        .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .run(run),
        .mem_ref(mem_ref), .ind_bit(ind_bit),
        .btn_load(btn_load), .btn_dep(btn_dep), .btn_exam(btn_exam),
        .st_fetch(st_fetch), .st_defer(st_defer), .st_exec(st_exec),
        .st_load(st_load), .st_dep(st_dep), .st_exam(st_exam),
        .halt_req(halt_req)
    );

    // State order {exam, dep, load, exec, defer, fetch}
    function automatic logic [5:0] st_now();
        return {st_exam, st_dep, st_load, st_exec, st_defer, st_fetch};
    endfunction

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Row: {req[3:0], run, cyc, mem, ind, ld, dp, ex, exp_state[5:0], exp_halt}
    localparam int NV = 22;
    localparam logic [17:0] VEC [NV] = '{
        {4'd3,  1'b0,1'b1,1'b1,1'b1, 3'b000, 6'b000001, 1'b0}, // R3 strobe while halted
        {4'd3,  1'b1,1'b0,1'b1,1'b1, 3'b000, 6'b000001, 1'b0}, // R3 no strobe
        {4'd4,  1'b1,1'b1,1'b0,1'b1, 3'b000, 6'b000001, 1'b0}, // R4 non-mem, ind ignored
        {4'd5,  1'b1,1'b1,1'b1,1'b0, 3'b000, 6'b000100, 1'b0}, // R5 direct
        {4'd9,  1'b1,1'b0,1'b0,1'b0, 3'b100, 6'b000100, 1'b0}, // R9 button while running
        {4'd11, 1'b1,1'b1,1'b1,1'b1, 3'b000, 6'b000001, 1'b0}, // R11 flags in execute
        {4'd6,  1'b1,1'b1,1'b1,1'b1, 3'b000, 6'b000010, 1'b0}, // R6 indirect
        {4'd6,  1'b1,1'b1,1'b0,1'b0, 3'b000, 6'b000100, 1'b0}, // R6 defer exit
        {4'd7,  1'b1,1'b1,1'b0,1'b0, 3'b010, 6'b000001, 1'b0}, // R7 with button
        {4'd8,  1'b0,1'b0,1'b0,1'b0, 3'b001, 6'b100000, 1'b0}, // R8 examine
        {4'd3,  1'b1,1'b0,1'b0,1'b0, 3'b000, 6'b100000, 1'b0}, // R3 wait for strobe
        {4'd10, 1'b1,1'b1,1'b1,1'b1, 3'b000, 6'b000001, 1'b1}, // R10 examine ends
        {4'd8,  1'b0,1'b0,1'b0,1'b0, 3'b111, 6'b001000, 1'b0}, // R8 all pressed
        {4'd8,  1'b0,1'b0,1'b0,1'b0, 3'b011, 6'b010000, 1'b0}, // R8 dep over exam
        {4'd10, 1'b1,1'b1,1'b0,1'b0, 3'b000, 6'b000001, 1'b1}, // R10 deposit ends
        {4'd8,  1'b0,1'b0,1'b0,1'b0, 3'b010, 6'b010000, 1'b0}, // R8 deposit
        {4'd11, 1'b1,1'b1,1'b1,1'b1, 3'b000, 6'b000001, 1'b1}, // R11 flags in panel
        {4'd6,  1'b1,1'b1,1'b1,1'b1, 3'b000, 6'b000010, 1'b0}, // R6 indirect again
        {4'd3,  1'b0,1'b1,1'b0,1'b0, 3'b000, 6'b000010, 1'b0}, // R3 halted strobe
        {4'd9,  1'b1,1'b0,1'b0,1'b0, 3'b111, 6'b000010, 1'b0}, // R9 in defer
        {4'd6,  1'b1,1'b1,1'b0,1'b0, 3'b000, 6'b000100, 1'b0}, // R6 defer exit
        {4'd7,  1'b1,1'b1,1'b0,1'b0, 3'b000, 6'b000001, 1'b0}  // R7 back to fetch
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        // Watchdog
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", st_now(), 6'b000001);
        check("R1 reset halt_req", {5'b0, halt_req}, 6'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            logic [17:0] v;
            string tag;
            v = VEC[k];
            tag = $sformatf("R%0d row %0d", v[17:14], k);
            @(negedge clk);
            run = v[13]; cyc_end = v[12]; mem_ref = v[11]; ind_bit = v[10];
            btn_load = v[9]; btn_dep = v[8]; btn_exam = v[7];
            #1;
            check({tag, " halt_req"}, {5'b0, halt_req}, {5'b0, v[0]});
            @(posedge clk);
            #1;
            check(tag, st_now(), v[6:1]);
            check("R2 one-hot", 6'($countones(st_now())), 6'd1);
        end

        // R1: reset from execute, with a live strobe and buttons
        @(negedge clk);
        run = 1'b1; cyc_end = 1'b1; mem_ref = 1'b1; ind_bit = 1'b0;
        btn_load = 1'b0; btn_dep = 1'b0; btn_exam = 1'b0;
        @(posedge clk); #1;
        check("R5 setup execute", st_now(), 6'b000100);
        @(negedge clk);
        rst_n = 1'b0; run = 1'b0; btn_dep = 1'b1;
        @(posedge clk); #1;
        check("R1 reset overrides", st_now(), 6'b000001);
        check("R1 halt_req in reset", {5'b0, halt_req}, 6'b0);
        @(negedge clk);
        rst_n = 1'b1; btn_dep = 1'b0; cyc_end = 1'b0;
        @(posedge clk); #1;
        check("R3 idle after reset", st_now(), 6'b000001);
        finish_run();
    end
endmodule